// File: doc/BRIEF.md
# Microcoded Multi-Cycle ADD Core

This block is a small processor core that finishes one instruction before it starts the next. Every instruction passes through a chain of register-transfer micro-steps. Each micro-step drives the control signals for exactly one clock cycle.

The control side holds an instruction pointer, an instruction register and a micro-step sequencer. The data side holds a memory address register, a memory data register, a sixteen-entry register file, an adder and a temporary result register. A small instruction store sits inside the core and is filled through a write port. A `halt` input freezes the core where it stands.

The core recognises two operations. ADD has three register operands and computes dest = srcA + srcB. Every other opcode behaves as a no-operation. For observation, the core brings out its instruction pointer, its instruction register, its micro-step code and a read-only view of any register.

The micro-steps, with their codes on `ustep_o`, are:
- ADDR (0): the address register takes the instruction pointer.
- READ (1): the data register takes the memory word.
- LOAD (2): the instruction register takes the data register.
- DECODE (3): the opcode is examined.
- EXEC (4): the sum goes into the temporary register.
- WBACK (5): the result is written back and the instruction pointer advances.

The transitions, which apply only while `halt` is low, are:
- ADDR→READ→LOAD→DECODE, one step per cycle.
- DECODE→EXEC for ADD.
- DECODE→WBACK for any other opcode.
- EXEC→WBACK.
- WBACK→ADDR.

Top module: `mc_core`

## Requirements
- R1: After reset:
  - `ustep_o` is 0 (ADDR).
  - `ip_o` is 0.
  - `ir_o` is 0.
  - Register k holds the value k, for k = 0..15.
- R2: With `halt` low, the fetch steps advance ADDR(0)→READ(1)→LOAD(2)→DECODE(3), one per clock. At the end of LOAD, `ir_o` equals the instruction-store word at index `ip_o[5:2]`.
- R3: An instruction with opcode `ir[31:24]` = 0x01 is an ADD. Its fields are dest = `ir[23:20]`, srcA = `ir[19:16]` and srcB = `ir[15:12]`.
  - It goes DECODE→EXEC→WBACK.
  - The sum is formed in EXEC from the register values at that time.
  - The register file changes only at the end of WBACK, when dest takes that sum.
- R4: Any other opcode, including 0x00 (NOP), goes DECODE→WBACK directly and leaves every register unchanged.
- R5: `ip_o` increases by 4 at the end of each WBACK step that is not halted, and at no other time.
- R6: After WBACK the next step is ADDR (0).
- R7: While `halt` is high, no state changes: micro-step, instruction pointer, instruction register and registers all hold.
- R8: Register 0 is an ordinary writable register. Sums wrap modulo 2^32. A destination that is also a source reads its old value.
- R9: The instruction store has 16 words, and the word fetched is index `ip_o[5:2]`, so the program repeats every 64 bytes of `ip_o`. A store write through `imem_we` lands at index `imem_waddr` on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Freeze all sequencing and state |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | 4 | Instruction store word index |
| imem_wdata | input | 32 | Instruction word to store |
| peek_sel | input | 4 | Register index to observe |
| peek_data | output | 32 | Value of the selected register |
| ip_o | output | 32 | Instruction pointer |
| ir_o | output | 32 | Instruction register |
| ustep_o | output | 3 | Current micro-step code |

## Verification
The bench builds the core with its default parameters: 32-bit data, 16 registers and a 16-word instruction store. With these values, a looping program of mixed ADDs, NOPs and an unknown opcode revisits every store slot several times. Repeated self-doubling of one register drives it through 2^32 and back through zero. A periodic `halt` pattern lands on every micro-step, including WBACK, where a frozen write or pointer advance would otherwise slip through.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic [2:0] {
        US_ADDR   = 3'd0,
        US_READ   = 3'd1,
        US_LOAD   = 3'd2,
        US_DECODE = 3'd3,
        US_EXEC   = 3'd4,
        US_WBACK  = 3'd5
    } ustep_e;

    typedef struct packed {
        logic mar_ld;
        logic mdr_ld;
        logic ir_ld;
        logic temp_ld;
        logic rf_we;
        logic ip_adv;
    } uctl_t;

    localparam logic [7:0] OPC_ADD = 8'h01;
endpackage

// File: rtl/mc_useq.sv
module mc_useq
    import mc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   halt,
    input  logic   is_add,
    output ustep_e step,
    output uctl_t  ctl
);
    ustep_e step_nx;

    always_comb begin
        step_nx = step;
        unique case (step)
            US_ADDR:   step_nx = US_READ;
            US_READ:   step_nx = US_LOAD;
            US_LOAD:   step_nx = US_DECODE;
            US_DECODE: step_nx = is_add ? US_EXEC : US_WBACK;
            US_EXEC:   step_nx = US_WBACK;
            US_WBACK:  step_nx = US_ADDR;
            default:   step_nx = US_ADDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            step <= US_ADDR;
        else if (!halt)
            step <= step_nx;
    end

    always_comb begin
        ctl = '0;
        if (!halt) begin
            unique case (step)
                US_ADDR:   ctl.mar_ld = 1'b1;
                US_READ:   ctl.mdr_ld = 1'b1;
                US_LOAD:   ctl.ir_ld = 1'b1;
                US_DECODE: ;
                US_EXEC:   ctl.temp_ld = 1'b1;
                US_WBACK: begin
                    ctl.rf_we  = is_add;
                    ctl.ip_adv = 1'b1;
                end
                default: ;
            endcase
        end
    end

    a_r2_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
        (step == US_ADDR && !halt) |=> (step == US_READ));
    a_r4_nop_skips_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (step == US_DECODE && !halt && !is_add) |=> (step == US_WBACK));
    a_r6_wback_return: assert property (@(posedge clk) disable iff (!rst_n)
        (step == US_WBACK && !halt) |=> (step == US_ADDR));
    a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(step));
endmodule

// File: rtl/mc_rf.sv
module mc_rf #(
    parameter int XLEN = 32,
    parameter int NREG = 16,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RAW-1:0]  wsel,
    input  logic [XLEN-1:0] wdata,
    input  logic [RAW-1:0]  rsel_a,
    input  logic [RAW-1:0]  rsel_b,
    input  logic [RAW-1:0]  rsel_p,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b,
    output logic [XLEN-1:0] rdata_p
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++)
                regs[k] <= XLEN'(k);
        end else if (we) begin
            regs[wsel] <= wdata;
        end
    end

    assign rdata_a = regs[rsel_a];
    assign rdata_b = regs[rsel_b];
    assign rdata_p = regs[rsel_p];

    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs[$past(wsel)] == $past(wdata)));
    a_r4_no_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (regs[$past(rsel_p)] == $past(rdata_p)));
endmodule

// File: rtl/mc_dpath.sv
module mc_dpath
    import mc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREG  = 16,
    parameter int IWORDS = 16,
    localparam int RAW = $clog2(NREG),
    localparam int IAW = $clog2(IWORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  uctl_t           ctl,
    input  logic            imem_we,
    input  logic [IAW-1:0]  imem_waddr,
    input  logic [XLEN-1:0] imem_wdata,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] temp,
    output logic [XLEN-1:0] ip,
    output logic [XLEN-1:0] ir,
    output logic            is_add,
    output logic [RAW-1:0]  dst,
    output logic [RAW-1:0]  srca,
    output logic [RAW-1:0]  srcb
);
    localparam int OPW = 8;

    logic [XLEN-1:0] imem [IWORDS];
    logic [IAW-1:0]  mar;
    logic [XLEN-1:0] mdr;

    always_ff @(posedge clk) begin
        if (imem_we)
            imem[imem_waddr] <= imem_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar  <= '0;
            mdr  <= '0;
            ir   <= '0;
            temp <= '0;
            ip   <= '0;
        end else begin
            if (ctl.mar_ld)  mar  <= ip[IAW+1:2];
            if (ctl.mdr_ld)  mdr  <= imem[mar];
            if (ctl.ir_ld)   ir   <= mdr;
            if (ctl.temp_ld) temp <= opa + opb;
            if (ctl.ip_adv)  ip   <= ip + XLEN'(4);
        end
    end

    assign is_add = (ir[XLEN-1 -: OPW] == OPC_ADD);
    assign dst    = ir[XLEN-OPW-1 -: RAW];
    assign srca   = ir[XLEN-OPW-RAW-1 -: RAW];
    assign srcb   = ir[XLEN-OPW-2*RAW-1 -: RAW];

    a_r5_ip_step: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ip_adv |=> (ip == $past(ip) + XLEN'(4)));
    a_r5_ip_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.ip_adv |=> $stable(ip));
    a_r2_ir_from_mdr: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ir_ld |=> (ir == $past(mdr)));
endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NREG   = 16,
    parameter int IWORDS = 16,
    localparam int RAW = $clog2(NREG),
    localparam int IAW = $clog2(IWORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt,
    input  logic            imem_we,
    input  logic [IAW-1:0]  imem_waddr,
    input  logic [XLEN-1:0] imem_wdata,
    input  logic [RAW-1:0]  peek_sel,
    output logic [XLEN-1:0] peek_data,
    output logic [XLEN-1:0] ip_o,
    output logic [XLEN-1:0] ir_o,
    output logic [2:0]      ustep_o
);
    ustep_e          step;
    uctl_t           ctl;
    logic            is_add;
    logic [RAW-1:0]  dst, srca, srcb;
    logic [XLEN-1:0] opa, opb, temp;

    mc_useq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .halt   (halt),
        .is_add (is_add),
        .step   (step),
        .ctl    (ctl)
    );

    mc_dpath #(.XLEN(XLEN), .NREG(NREG), .IWORDS(IWORDS)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl        (ctl),
        .imem_we    (imem_we),
        .imem_waddr (imem_waddr),
        .imem_wdata (imem_wdata),
        .opa        (opa),
        .opb        (opb),
        .temp       (temp),
        .ip         (ip_o),
        .ir         (ir_o),
        .is_add     (is_add),
        .dst        (dst),
        .srca       (srca),
        .srcb       (srcb)
    );

    mc_rf #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctl.rf_we),
        .wsel    (dst),
        .wdata   (temp),
        .rsel_a  (srca),
        .rsel_b  (srcb),
        .rsel_p  (peek_sel),
        .rdata_a (opa),
        .rdata_b (opb),
        .rdata_p (peek_data)
    );

    assign ustep_o = step;

    a_r7_halt_ip: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(ip_o));
    a_r7_halt_ir: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(ir_o));
endmodule

// File: tb/mc_core_tb.sv
`timescale 1ns/1ps
module mc_core_tb_top;
    localparam real CLK_PERIOD = 10.0;
    localparam int  RUN_CYCLES = 900;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt = 1'b0;
    logic        imem_we = 1'b0;
    logic [3:0]  imem_waddr = '0;
    logic [31:0] imem_wdata = '0;
    logic [3:0]  peek_sel = '0;
    logic [31:0] peek_data, ip_o, ir_o;
    logic [2:0]  ustep_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int unsigned m_rf [16];
    int unsigned m_mem [16];
    int unsigned m_ip, m_ir, m_mdr, m_temp;
    int          m_mar, m_step;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_core dut_i (
        .clk(clk), .rst_n(rst_n), .halt(halt),
        .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
        .peek_sel(peek_sel), .peek_data(peek_data),
        .ip_o(ip_o), .ir_o(ir_o), .ustep_o(ustep_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_step = 0; m_ip = 0; m_ir = 0; m_mdr = 0; m_temp = 0; m_mar = 0;
            for (int k = 0; k < 16; k++) m_rf[k] = k;
        end else if (!halt) begin
            case (m_step)
                0: begin m_mar = (m_ip >> 2) % 16; m_step = 1; end
                1: begin m_mdr = m_mem[m_mar]; m_step = 2; end
                2: begin m_ir = m_mdr; m_step = 3; end
                3: m_step = ((m_ir >> 24) == 1) ? 4 : 5;
                4: begin
                    m_temp = m_rf[(m_ir >> 16) & 15] + m_rf[(m_ir >> 12) & 15];
                    m_step = 5;
                end
                default: begin
                    if ((m_ir >> 24) == 1) m_rf[(m_ir >> 20) & 15] = m_temp;
                    m_ip = m_ip + 4;
                    m_step = 0;
                end
            endcase
        end
    end

    task automatic check(string req, int unsigned act, int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_regs(string req);
        for (int k = 0; k < 16; k++) begin
            peek_sel = 4'(k);
            #0.1;
            check(req, peek_data, m_rf[k]);
        end
    endtask

    function automatic int unsigned add_op(int d, int a, int b);
        return (32'h01 << 24) | (d << 20) | (a << 16) | (b << 12);
    endfunction

    task automatic load_word(int idx, int unsigned w);
        @(negedge clk);
        imem_we = 1'b1; imem_waddr = 4'(idx); imem_wdata = w;
        m_mem[idx] = w;
        @(negedge clk);
        imem_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // program: ADDs, NOP (R4), unknown opcode (R4), r0 dest (R8), self-doubling wrap (R8)
        load_word(0,  add_op(2, 1, 3));
        load_word(1,  32'h0000_0000);
        load_word(2,  add_op(0, 5, 6));
        load_word(3,  add_op(7, 7, 7));
        load_word(4,  32'h7F12_3000);
        load_word(5,  add_op(15, 15, 15));
        load_word(6,  add_op(15, 15, 15));
        load_word(7,  add_op(4, 0, 2));
        load_word(8,  add_op(15, 15, 15));
        load_word(9,  add_op(15, 15, 15));
        load_word(10, add_op(15, 15, 15));
        load_word(11, add_op(14, 15, 7));
        load_word(12, add_op(15, 15, 15));
        load_word(13, 32'h0000_0000);
        load_word(14, add_op(15, 15, 15));
        load_word(15, add_op(3, 3, 3));
        @(negedge clk);
        // R1: reset state
        check("R1 ustep", ustep_o, 0);
        check("R1 ip", ip_o, 0);
        check("R1 ir", ir_o, 0);
        check_regs("R1 regs");
        rst_n = 1'b1;
        for (int c = 0; c < RUN_CYCLES; c++) begin
            @(negedge clk);
            if (m_step == 2 || m_step == 3)
                check("R2 ustep fetch", ustep_o, m_step);
            else if (m_step == 0)
                check("R6 ustep after wback", ustep_o, m_step);
            else
                check("R3 ustep", ustep_o, m_step);
            check("R5 ip", ip_o, m_ip);
            check("R2 ir", ir_o, m_ir);
            if (halt) check_regs("R7 regs under halt");
            else if ((m_ir >> 24) != 1) check_regs("R4 regs after non-add");
            else check_regs("R3 regs");
            #1;
            // halt pattern covers every micro-step, including WBACK (R7)
            halt = (c > 250 && c < 600 && (c % 5 == 2 || c % 7 == 0));
        end
        halt = 1'b0;
        // R9: fetched word index wraps every 64 bytes of ip
        check("R9 ip past wrap", (ip_o > 64) ? 1 : 0, 1);
        check_regs("R8 final regs");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule